// File: doc/BRIEF.md
# Banked Register File with Indirect Addressing

This block turns the 5-bit register-file operand of an instruction into one physical data location. Operands 0x10 to 0x1F reach a banked window, selected by high bits of a pointer register. Operands 0x01 to 0x0F always reach the common area, which holds the timer, program-counter low byte, status and port latches as plain storage, plus general-purpose bytes. Operand 0x00 is not storage: it redirects to the location named by the pointer's low five bits. The pointer itself lives at 0x04.

A separate configuration path loads an option register and one direction register per port from the accumulator. It is driven by a dedicated strobe that uses the operand as a selector. These registers sit outside the address map and are brought out as outputs for the timer and pin logic.

Reads are registered. With `rd_en` high at a clock edge, `rd_data` shows the addressed value after that edge and holds it until the next read. Writes take effect at the edge where `wr_en` is high.

Top module: `banked_regfile`

## Requirements
- R1: With `wr_en` high, `wr_data` is stored at the resolved location at that edge. With `rd_en` high, `rd_data` shows the resolved location's value after that edge. A read and a write in the same cycle return the value from before the write.
- R2: After reset, every storage byte reads 0x00 and the implemented pointer bits are 0.
- R3: Operand 0x00 reads and writes the location whose operand is the pointer's bits 4:0. That location may be in the common area, the banked area or the pointer itself.
- R4: Operands 0x10 to 0x1F, direct or indirect, reach bank `ptr[6:5]` with 4 banks, `ptr[7:5]` with 8 banks, and a single bank with 1 bank. Operands 0x01 to 0x0F reach the same byte whatever the bank bits are.
- R5: An indirect access whose pointer bits 4:0 are 0x00 reads 0x00, and a write through it changes no stored byte.
- R6: The pointer is 5, 7 or 8 bits wide for 1, 4 or 8 banks. Its unimplemented high bits read as ones.
- R7: A configuration strobe with selector 2 loads `acc` into the option register.
- R8: A configuration strobe with selector 5+p, for p below the port count, loads `acc` into direction register p. Any other selector changes no configuration register.
- R9: On reset, the option register and every direction register become 0xFF.
- R10: Ordinary file writes never change the option or direction registers. Those registers change only on a configuration strobe.
- R11: `rd_data` holds its value in every cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| file_addr | input | 5 | Register-file operand, also the configuration selector |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| acc | input | 8 | Accumulator value for configuration loads |
| cfg_wr | input | 1 | Configuration load strobe |
| rd_data | output | 8 | Registered read data |
| opt_q | output | 8 | Option register |
| dir_q | output | 8*NUM_PORTS | Direction registers, port p in bits 8p+7:8p |

## Verification
The hardest case to reach is an indirect access that lands in a banked byte. The pointer first has to be written at 0x04 with both a bank number and a banked offset. The same byte must then be reached through 0x00 and read back by a direct access under that bank. The bench walks the pointer through every bank and fills each window with bytes that tag the bank. It then does this round trip, and also points the pointer at 0x00 with non-zero bank bits to test the null case. A long pseudo-random mix of direct, indirect and pointer writes, checked against an array model, covers the orderings that directed steps leave out.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

    typedef enum logic [1:0] {
        TGT_NULL,
        TGT_PTR,
        TGT_MEM
    } tgt_e;

    localparam logic [4:0] OPND_INDIRECT = 5'h00;
    localparam logic [4:0] OPND_POINTER  = 5'h04;
    localparam logic [4:0] CFG_SEL_OPT   = 5'h02;
    localparam int unsigned CFG_DIR_BASE = 5;
    localparam int unsigned WIN_SIZE     = 16;

    function automatic int unsigned ptr_width(input int unsigned banks);
        if (banks >= 8)      return 8;
        else if (banks >= 4) return 7;
        else                 return 5;
    endfunction

endpackage

// File: rtl/rbf_addr_resolve.sv
module rbf_addr_resolve
    import rbf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned PTR_W     = 7,
    parameter int unsigned IDX_W     = 7
) (
    input  logic [4:0]       opnd,
    input  logic [PTR_W-1:0] ptr,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] mem_idx
);
    localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [4:0]        eff;
    logic [BANK_W-1:0] bank;

    generate
        if (NUM_BANKS > 1) begin : g_banked
            assign bank = ptr[5 +: BANK_W];
        end else begin : g_flat
            assign bank = '0;
        end
    endgenerate

    assign eff = (opnd == OPND_INDIRECT) ? ptr[4:0] : opnd;

    always_comb begin
        unique case (eff)
            OPND_INDIRECT: tgt = TGT_NULL;
            OPND_POINTER:  tgt = TGT_PTR;
            default:       tgt = TGT_MEM;
        endcase
    end

    always_comb begin
        if (eff[4])
            mem_idx = IDX_W'(WIN_SIZE + WIN_SIZE * int'(bank) + int'(eff[3:0]));
        else
            mem_idx = IDX_W'(eff[3:0]);
    end

endmodule

// File: rtl/rbf_store.sv
module rbf_store #(
    parameter int unsigned DEPTH = 80,
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_val
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en && (int'(idx) < DEPTH)) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_val = (int'(idx) < DEPTH) ? mem[idx] : 8'h00;

    // R1: a write is visible at its location on the following cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(idx) < DEPTH) |=> (mem[$past(idx)] == $past(wr_data)));

endmodule

// File: rtl/rbf_cfg_regs.sv
module rbf_cfg_regs
    import rbf_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [4:0]             sel,
    input  logic [7:0]             acc,
    output logic [7:0]             opt_q,
    output logic [8*NUM_PORTS-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)                           opt_q <= 8'hFF;
        else if (cfg_wr && sel == CFG_SEL_OPT) opt_q <= acc;
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dir
            localparam logic [4:0] MY_SEL = 5'(CFG_DIR_BASE + p);
            always_ff @(posedge clk) begin
                if (!rst_n)                      dir_q[8*p +: 8] <= 8'hFF;
                else if (cfg_wr && sel == MY_SEL) dir_q[8*p +: 8] <= acc;
            end
        end
    endgenerate

    // R7: selector 2 loads the accumulator into the option register
    a_r7_opt_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sel == CFG_SEL_OPT) |=> (opt_q == $past(acc)));

    // R10: configuration registers move only on a configuration strobe
    a_r10_opt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(opt_q));
    a_r10_dir_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(dir_q));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rbf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [4:0]             file_addr,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [7:0]             wr_data,
    input  logic [7:0]             acc,
    input  logic                   cfg_wr,
    output logic [7:0]             rd_data,
    output logic [7:0]             opt_q,
    output logic [8*NUM_PORTS-1:0] dir_q
);
    localparam int unsigned PTR_W  = ptr_width(NUM_BANKS);
    localparam int unsigned DEPTH  = WIN_SIZE * (NUM_BANKS + 1);
    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam logic [7:0] PTR_ONES = ~8'((9'h1 << PTR_W) - 9'h1);

    logic [PTR_W-1:0] ptr_q;
    tgt_e             tgt;
    logic [IDX_W-1:0] mem_idx;
    logic [7:0]       mem_val;
    logic [7:0]       rd_next;

    rbf_addr_resolve #(
        .NUM_BANKS (NUM_BANKS),
        .PTR_W     (PTR_W),
        .IDX_W     (IDX_W)
    ) u_resolve (
        .opnd    (file_addr),
        .ptr     (ptr_q),
        .tgt     (tgt),
        .mem_idx (mem_idx)
    );

    rbf_store #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && tgt == TGT_MEM),
        .idx     (mem_idx),
        .wr_data (wr_data),
        .rd_val  (mem_val)
    );

    rbf_cfg_regs #(
        .NUM_PORTS (NUM_PORTS)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .sel    (file_addr),
        .acc    (acc),
        .opt_q  (opt_q),
        .dir_q  (dir_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                         ptr_q <= '0;
        else if (wr_en && tgt == TGT_PTR)   ptr_q <= wr_data[PTR_W-1:0];
    end

    always_comb begin
        unique case (tgt)
            TGT_NULL: rd_next = 8'h00;
            TGT_PTR:  rd_next = PTR_ONES | 8'(ptr_q);
            default:  rd_next = mem_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

    // R5: an indirect access through a null pointer reads zero
    a_r5_null_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && file_addr == OPND_INDIRECT && ptr_q[4:0] == 5'h00) |=> (rd_data == 8'h00));

    // R6: unimplemented pointer bits read back as ones
    a_r6_ptr_high_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && file_addr == OPND_POINTER) |=> ((rd_data & PTR_ONES) == PTR_ONES));

    // R11: read data holds while no read is requested
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
    localparam int NB = 4;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    file_addr = '0;
    logic          rd_en = 1'b0, wr_en = 1'b0, cfg_wr = 1'b0;
    logic [7:0]    wr_data = '0, acc = '0;
    logic [7:0]    rd_data, opt_q;
    logic [8*NP-1:0] dir_q;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [7:0] ref_mem [16*(NB+1)];
    logic [6:0] ref_ptr;
    logic [7:0] ref_opt;
    logic [7:0] ref_dir [NP];

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    banked_regfile #(.NUM_BANKS(NB), .NUM_PORTS(NP)) u_banked_regfile (
        .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .acc(acc), .cfg_wr(cfg_wr),
        .rd_data(rd_data), .opt_q(opt_q), .dir_q(dir_q));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] eff_of(input logic [4:0] a);
        return (a == 5'h00) ? ref_ptr[4:0] : a;
    endfunction

    function automatic int idx_of(input logic [4:0] e);
        if (e[4]) return 16 + 16 * int'(ref_ptr[6:5]) + int'(e[3:0]);
        return int'(e);
    endfunction

    function automatic logic [7:0] model_read(input logic [4:0] a);
        logic [4:0] e;
        e = eff_of(a);
        if (e == 5'h00) return 8'h00;
        if (e == 5'h04) return {1'b1, ref_ptr};
        return ref_mem[idx_of(e)];
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [7:0] d);
        logic [4:0] e;
        e = eff_of(a);
        if (e == 5'h04)       ref_ptr = d[6:0];
        else if (e != 5'h00)  ref_mem[idx_of(e)] = d;
    endtask

    // driver
    task automatic access(input logic r, input logic w, input logic [4:0] a,
                          input logic [7:0] d, input string tag);
        @(negedge clk);
        rd_en = r; wr_en = w; cfg_wr = 1'b0; file_addr = a; wr_data = d;
        if (r) begin
            exp_q.push_back(model_read(a));
            tag_q.push_back(tag);
        end
        if (w) model_write(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0; cfg_wr = 1'b0;
        end
    endtask

    task automatic cfg(input logic [4:0] sel, input logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; cfg_wr = 1'b1; file_addr = sel; acc = v;
        if (sel == 5'd2) ref_opt = v;
        for (int p = 0; p < NP; p++) if (int'(sel) == 5 + p) ref_dir[p] = v;
    endtask

    task automatic chk_cfg(input string tag);
        chk({tag, " opt"}, opt_q, ref_opt);
        for (int p = 0; p < NP; p++) chk({tag, " dir"}, dir_q[8*p +: 8], ref_dir[p]);
    endtask

    // monitor
    always @(posedge clk) begin
        logic was_rd;
        was_rd = rd_en && rst_n;
        #2;
        if (was_rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1 unexpected read actual=%02h expected=none", rd_data);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [7:0]  held;
        for (int i = 0; i < 16*(NB+1); i++) ref_mem[i] = 8'h00;
        ref_ptr = '0; ref_opt = 8'hFF;
        for (int p = 0; p < NP; p++) ref_dir[p] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 / R9 reset state
        access(1, 0, 5'h01, 0, "R2 timer reset");
        access(1, 0, 5'h0F, 0, "R2 common reset");
        access(1, 0, 5'h1A, 0, "R2 bank reset");
        access(1, 0, 5'h04, 0, "R6 ptr reset reads 80");
        idle(2);
        chk_cfg("R9 reset");

        // R1 common area
        for (int a = 1; a < 16; a++)
            if (a != 4) access(0, 1, 5'(a), 8'(8'h30 + a), "");
        for (int a = 1; a < 16; a++)
            if (a != 4) access(1, 0, 5'(a), 0, "R1 common readback");

        // R4 fill every bank
        for (int b = 0; b < NB; b++) begin
            access(0, 1, 5'h04, 8'(b << 5), "");
            for (int o = 0; o < 16; o++) access(0, 1, 5'(16 + o), 8'({b[3:0], o[3:0]}), "");
        end
        for (int b = 0; b < NB; b++) begin
            access(0, 1, 5'h04, 8'(b << 5), "");
            for (int o = 0; o < 16; o += 5) access(1, 0, 5'(16 + o), 0, "R4 bank readback");
            access(1, 0, 5'h07, 0, "R4 common unaffected by bank");
        end

        // R3 indirect into common and banked
        access(0, 1, 5'h04, 8'h0A, "");
        access(0, 1, 5'h00, 8'hA5, "");
        access(1, 0, 5'h0A, 0, "R3 indirect write common");
        access(1, 0, 5'h00, 0, "R3 indirect read common");
        access(0, 1, 5'h04, 8'h75, "");
        access(0, 1, 5'h00, 8'h5A, "");
        access(1, 0, 5'h15, 0, "R3 indirect write banked");
        access(0, 1, 5'h04, 8'h35, "");
        access(1, 0, 5'h15, 0, "R4 other bank untouched");
        access(0, 1, 5'h04, 8'h04, "");
        access(1, 0, 5'h00, 0, "R3 indirect to pointer");

        // R5 null pointer
        access(0, 1, 5'h04, 8'h20, "");
        access(1, 0, 5'h00, 0, "R5 null reads zero");
        access(0, 1, 5'h00, 8'hEE, "");
        access(1, 0, 5'h00, 0, "R5 null after write");
        access(1, 0, 5'h10, 0, "R5 bank byte untouched");
        access(1, 0, 5'h01, 0, "R5 common untouched");

        // R6 pointer width
        access(0, 1, 5'h04, 8'hFF, "");
        access(1, 0, 5'h04, 0, "R6 ptr all ones");
        access(0, 1, 5'h04, 8'h00, "");
        access(1, 0, 5'h04, 0, "R6 ptr high bit one");

        // R1 read during write, R11 hold
        access(1, 1, 5'h03, 8'h99, "R1 read old during write");
        access(1, 0, 5'h03, 0, "R1 new value");
        idle(1);
        @(negedge clk);
        held = rd_data;
        wr_en = 1'b1; file_addr = 5'h03; wr_data = 8'h11; model_write(5'h03, 8'h11);
        @(negedge clk);
        wr_en = 1'b0; file_addr = 5'h08;
        @(negedge clk);
        chk("R11 rd_data hold", rd_data, held);

        // R7 / R8 / R10 configuration
        cfg(5'd2, 8'h3C); idle(1); chk_cfg("R7 option load");
        cfg(5'd5, 8'h01); cfg(5'd6, 8'h02); cfg(5'd7, 8'h03); idle(1);
        chk_cfg("R8 direction load");
        cfg(5'd3, 8'h77); cfg(5'd4, 8'h77); cfg(5'd8, 8'h77); cfg(5'd1, 8'h77); cfg(5'd0, 8'h77);
        idle(1); chk_cfg("R8 other selectors ignored");
        access(0, 1, 5'h02, 8'h44, ""); access(0, 1, 5'h05, 8'h44, ""); access(0, 1, 5'h06, 8'h44, "");
        idle(1); chk_cfg("R10 file write leaves config");

        // R1 R3 R4 random mix against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[0], lfsr[1], lfsr[6:2], lfsr[15:8], "R4 random mix");
        end
        idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule